// File: doc/BRIEF.md
# Commit-Point Exception Controller

This block is the exception control path of an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. A fault is not acted on in the stage that detects it. The fault is recorded in a small tag that travels with the instruction: a pending bit plus a cause code. The fault is resolved only when the instruction reaches the memory stage, which is the commit point. Instructions older than the faulting one therefore finish normally. Younger instructions are discarded together with it.

When an exception is taken at commit, the block does four things in the same cycle. It asserts a kill for every stage, presents the fixed handler address as the redirect target for fetch, and withholds the memory write of the committing instruction. On the next edge it loads the cause and exception-PC registers, and the killed instruction never shows up as a writeback. An external interrupt line is sampled only at commit. It takes precedence over whatever fault the committing instruction carries. The datapath is outside the block: it supplies the fault indications and the fetch PC, and it obeys the kill, redirect and write-enable outputs.

Top module: `exc_commit_ctl`

## Requirements
- R1: During and just after reset, `cause_o` and `epc_o` are zero, `redirect_valid_o`, `kill_o`, `mem_write_ok_o` and `wb_valid_o` are low, and no stage holds a valid instruction.
- R2: A fault flagged in fetch, decode or execute does not redirect at once. It produces `redirect_valid_o` only in the cycle when its instruction occupies the memory stage: 2 cycles after the decode flag, 1 cycle after the execute flag, and 3 cycles after the fetch that carried the fetch fault.
- R3: Cause codes are fetch fault = 1, illegal opcode = 2, overflow = 3 and data address fault = 4. When one instruction collects several faults, the code of the earliest stage is reported.
- R4: An external interrupt is taken only when the memory stage holds a valid instruction. It then overrides any fault of that instruction and reports cause 0. With the memory stage empty, the interrupt has no effect.
- R5: On the clock edge that ends a taken-exception cycle, `cause_o` is loaded with the chosen code and `epc_o` with the PC of the instruction at commit. In every other cycle both registers hold their value.
- R6: In a taken-exception cycle `kill_o` is all ones (bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory), and `redirect_pc_o` equals `HANDLER_PC`. Otherwise `kill_o` is zero.
- R7: The instructions in decode and execute, and the fetch input present during a taken-exception cycle, are discarded. None of them ever reaches commit, writes memory or writes back.
- R8: `mem_write_ok_o` is high exactly when the memory stage holds a valid instruction and no exception is taken. `wb_valid_o` is high in the cycle after an instruction leaves the memory stage without an exception.
- R9: Fault inputs for a stage that holds no valid instruction are ignored.
- R10: An older instruction faulting at commit wins over younger instructions that have already flagged faults. The younger ones are discarded without affecting cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | A fetched instruction enters decode at the next edge |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| fetch_fault_i | input | 1 | Fetch of this instruction faulted |
| dec_illegal_i | input | 1 | Instruction in decode has an illegal opcode |
| exe_overflow_i | input | 1 | Instruction in execute overflowed |
| mem_addr_fault_i | input | 1 | Instruction in memory stage has a bad data address |
| ext_irq_i | input | 1 | External interrupt request |
| kill_o | output | 4 | Per-stage kill, bit 0 fetch to bit 3 memory |
| redirect_valid_o | output | 1 | Exception taken this cycle, fetch must redirect |
| redirect_pc_o | output | PC_W | Handler address when redirecting |
| mem_write_ok_o | output | 1 | Committing instruction may write memory |
| wb_valid_o | output | 1 | Writeback-stage instruction may update registers |
| cause_o | output | CAUSE_W | Cause register |
| epc_o | output | PC_W | Exception PC register |

## Verification
The two functions that can fall in one cycle are a synchronous fault and an interrupt, both resolved at commit. A data address fault raised at the memory stage can also meet a fault the same instruction already carries from an earlier stage. The bench provokes both cases by pulsing `ext_irq_i` and `mem_addr_fault_i` while a pre-flagged instruction sits in the memory stage. It judges the outcome from the cause code loaded on the next edge, and from the fact that exactly one redirect occurs with every younger instruction gone. A long mixed stream with sparse faults and interrupts then runs against a behavioural reference model that checks every output on every clock.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    localparam int PC_W     = 32;
    localparam int CAUSE_W  = 3;
    // number of pipeline registers tracked: decode, execute, memory
    localparam int PIPE_REGS  = 3;
    // stages that can be killed: fetch plus the tracked ones
    localparam int KILL_W     = PIPE_REGS + 1;

    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [PC_W-1:0]    pc_t;

    // cause codes, ordered by the stage that raises them
    localparam cause_t CAUSE_IRQ     = cause_t'(0);
    localparam cause_t CAUSE_FETCH   = cause_t'(1);
    localparam cause_t CAUSE_ILLEGAL = cause_t'(2);
    localparam cause_t CAUSE_OVF     = cause_t'(3);
    localparam cause_t CAUSE_DADDR   = cause_t'(4);

    // exception tag carried with each instruction
    typedef struct packed {
        logic   valid;
        pc_t    pc;
        logic   pend;
        cause_t cause;
    } slot_t;

endpackage

// File: rtl/exc_merge.sv
// Adds a stage-local fault to the tag of the instruction in that stage.
// A fault already pending from an older stage is kept unchanged.
module exc_merge
    import exc_ctl_pkg::*;
#(
    parameter cause_t CODE = CAUSE_ILLEGAL
) (
    input  slot_t slot_i,
    input  logic  fault_i,
    output slot_t slot_o
);
    always_comb begin
        slot_o = slot_i;
        if (slot_i.valid && !slot_i.pend && fault_i) begin
            slot_o.pend  = 1'b1;
            slot_o.cause = CODE;
        end
    end
endmodule

// File: rtl/exc_slot_reg.sv
// One pipeline register for the exception tag, cleared on flush.
module exc_slot_reg
    import exc_ctl_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  flush_i,
    input  slot_t slot_i,
    output slot_t slot_o
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_i;
        if (flush_i) begin
            slot_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot_o = slot_q;
endmodule

// File: rtl/exc_commit.sv
// Commit-point decision: interrupt overrides, otherwise the tag's cause.
module exc_commit
    import exc_ctl_pkg::*;
(
    input  slot_t  head_i,
    input  logic   irq_i,
    output logic   take_o,
    output cause_t cause_o,
    output pc_t    epc_o,
    output logic   retire_o
);
    always_comb begin
        take_o   = 1'b0;
        cause_o  = head_i.cause;
        epc_o    = head_i.pc;
        retire_o = 1'b0;
        if (head_i.valid) begin
            if (irq_i) begin
                take_o  = 1'b1;
                cause_o = CAUSE_IRQ;
            end else if (head_i.pend) begin
                take_o  = 1'b1;
            end else begin
                retire_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_commit_ctl.sv
module exc_commit_ctl
    import exc_ctl_pkg::*;
#(
    parameter pc_t HANDLER_PC = pc_t'(32'h0000_0100)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fetch_valid_i,
    input  logic [PC_W-1:0]    fetch_pc_i,
    input  logic               fetch_fault_i,
    input  logic               dec_illegal_i,
    input  logic               exe_overflow_i,
    input  logic               mem_addr_fault_i,
    input  logic               ext_irq_i,
    output logic [KILL_W-1:0]  kill_o,
    output logic               redirect_valid_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    output logic               mem_write_ok_o,
    output logic               wb_valid_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [PC_W-1:0]    epc_o
);
    localparam int HEAD = PIPE_REGS - 1;

    typedef struct packed {
        cause_t cause;
        pc_t    epc;
        logic   wb_valid;
    } ctl_t;

    slot_t             fetch_slot;
    slot_t             slot_in  [PIPE_REGS];
    slot_t             slot_q   [PIPE_REGS];
    slot_t             merged   [PIPE_REGS];
    logic [PIPE_REGS-1:0] stage_fault;

    logic   take;
    logic   retire;
    cause_t take_cause;
    pc_t    take_epc;

    ctl_t ctl_d, ctl_q;

    // fetch fault is the oldest possible tag source
    always_comb begin
        fetch_slot.valid = fetch_valid_i;
        fetch_slot.pc    = fetch_pc_i;
        fetch_slot.pend  = fetch_valid_i && fetch_fault_i;
        fetch_slot.cause = fetch_fault_i ? CAUSE_FETCH : CAUSE_IRQ;
    end

    assign stage_fault = {mem_addr_fault_i, exe_overflow_i, dec_illegal_i};

    for (genvar k = 0; k < PIPE_REGS; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign slot_in[k] = fetch_slot;
        end else begin : g_next
            assign slot_in[k] = merged[k-1];
        end

        exc_slot_reg u_reg (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .flush_i(take),
            .slot_i (slot_in[k]),
            .slot_o (slot_q[k])
        );

        exc_merge #(
            .CODE(cause_t'(int'(CAUSE_ILLEGAL) + k))
        ) u_merge (
            .slot_i (slot_q[k]),
            .fault_i(stage_fault[k]),
            .slot_o (merged[k])
        );
    end

    exc_commit u_commit (
        .head_i  (merged[HEAD]),
        .irq_i   (ext_irq_i),
        .take_o  (take),
        .cause_o (take_cause),
        .epc_o   (take_epc),
        .retire_o(retire)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.wb_valid = retire;
        if (take) begin
            ctl_d.cause = take_cause;
            ctl_d.epc   = take_epc;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign kill_o           = {KILL_W{take}};
    assign redirect_valid_o = take;
    assign redirect_pc_o    = take ? HANDLER_PC : '0;
    assign mem_write_ok_o   = retire;
    assign wb_valid_o       = ctl_q.wb_valid;
    assign cause_o          = ctl_q.cause;
    assign epc_o            = ctl_q.epc;
endmodule

// File: rtl/exc_commit_ctl_chk.sv
module exc_commit_ctl_chk
    import exc_ctl_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               ext_irq_i,
    input logic [KILL_W-1:0]  kill_o,
    input logic               redirect_valid_o,
    input logic               mem_write_ok_o,
    input logic               wb_valid_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [PC_W-1:0]    epc_o
);
    // R5
    regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !redirect_valid_o |=> ($stable(cause_o) && $stable(epc_o)));

    // R4
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect_valid_o && ext_irq_i) |=> (cause_o == CAUSE_IRQ));

    // R8
    no_wb_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |=> !wb_valid_o);

    // R8
    no_mem_write_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |-> !mem_write_ok_o);

    // R7
    no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |=> !redirect_valid_o);

    // R6
    kill_only_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kill_o != '0) |-> redirect_valid_o);

    // R3
    cause_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_o <= CAUSE_DADDR);
endmodule

bind exc_commit_ctl exc_commit_ctl_chk u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ext_irq_i       (ext_irq_i),
    .kill_o          (kill_o),
    .redirect_valid_o(redirect_valid_o),
    .mem_write_ok_o  (mem_write_ok_o),
    .wb_valid_o      (wb_valid_o),
    .cause_o         (cause_o),
    .epc_o           (epc_o)
);

// File: tb/exc_commit_ctl_tb.sv
module exc_commit_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fv = 1'b0;
    logic [31:0] fpc = '0;
    logic        ff = 1'b0, ill = 1'b0, ovf = 1'b0, daf = 1'b0, irq = 1'b0;
    logic [3:0]  kill;
    logic        rdv, mok, wbv;
    logic [31:0] rpc, epc;
    logic [2:0]  cause;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model state: index 0 decode, 1 execute, 2 memory; cause -1 = none
    bit          mv [3];
    logic [31:0] mp [3];
    int          mc [3];
    int          e_cause = 0;
    logic [31:0] e_epc = '0;
    bit          e_wb = 0;
    int          redirects = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_commit_ctl #(.HANDLER_PC(HANDLER)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .fetch_valid_i(fv), .fetch_pc_i(fpc), .fetch_fault_i(ff),
        .dec_illegal_i(ill), .exe_overflow_i(ovf), .mem_addr_fault_i(daf),
        .ext_irq_i(irq),
        .kill_o(kill), .redirect_valid_o(rdv), .redirect_pc_o(rpc),
        .mem_write_ok_o(mok), .wb_valid_o(wbv), .cause_o(cause), .epc_o(epc)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int merge(input bit v, input int c, input bit f, input int code);
        return (v && c < 0 && f) ? code : c;
    endfunction

    // one cycle: drive at negedge, compare, then advance the model
    task automatic step(input bit i_fv, input logic [31:0] i_pc, input bit i_ff,
                        input bit i_ill, input bit i_ovf, input bit i_daf, input bit i_irq);
        int  hc;
        bit  take;
        int  tc;
        @(negedge clk);
        fv = i_fv; fpc = i_pc; ff = i_ff; ill = i_ill; ovf = i_ovf; daf = i_daf; irq = i_irq;
        #1;
        hc   = merge(mv[2], mc[2], i_daf, 4);
        take = mv[2] && (i_irq || hc >= 0);
        tc   = i_irq ? 0 : hc;
        check("R2/R6 redirect", rdv, take);
        check("R6 kill", kill, take ? 4'hF : 4'h0);
        if (take) check("R6 handler", rpc, HANDLER);
        check("R8 mem_write_ok", mok, mv[2] && !take);
        check("R7/R8 wb_valid", wbv, e_wb);
        check("R3/R4/R5 cause", cause, e_cause);
        check("R5 epc", epc, e_epc);
        if (take) begin
            redirects++;
            e_cause = tc;
            e_epc   = mp[2];
            e_wb    = 0;
            for (int k = 0; k < 3; k++) begin mv[k] = 0; mc[k] = -1; end
        end else begin
            e_wb  = mv[2];
            mv[2] = mv[1]; mp[2] = mp[1]; mc[2] = merge(mv[1], mc[1], i_ovf, 3);
            mv[1] = mv[0]; mp[1] = mp[0]; mc[1] = merge(mv[0], mc[0], i_ill, 2);
            mv[0] = i_fv;  mp[0] = i_pc;  mc[0] = (i_fv && i_ff) ? 1 : -1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int r0;
        for (int k = 0; k < 3; k++) begin mv[k] = 0; mp[k] = '0; mc[k] = -1; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cause", cause, 0);
        check("R1 epc", epc, 0);
        check("R1 redirect", rdv, 0);
        check("R1 wb", wbv, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // clean stream, no faults (R8)
        for (int i = 0; i < 6; i++) step(1, 32'h1000 + 4*i, 0, 0, 0, 0, 0);
        idle(4);

        // R2/R3: illegal flagged in decode, taken two cycles later
        r0 = redirects;
        step(1, 32'h2000, 0, 0, 0, 0, 0);
        step(1, 32'h2004, 0, 1, 0, 0, 0);
        step(1, 32'h2008, 0, 0, 0, 0, 0);
        check("R2 no early redirect", redirects - r0, 0);
        step(1, 32'h200C, 0, 0, 0, 0, 0);
        check("R2 redirect at commit", redirects - r0, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        check("R3 illegal cause", cause, 2);
        check("R5 epc of illegal", epc, 32'h2000);
        idle(4);
        // R7: younger instructions 2004/2008 and 200C never retire
        check("R7 squashed no redirect", redirects - r0, 1);

        // R3: fetch fault and illegal on one instruction -> fetch wins
        step(1, 32'h3000, 1, 0, 0, 0, 0);
        step(0, '0, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 1, 0, 0);
        step(0, '0, 0, 0, 0, 1, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        check("R3 fetch beats illegal", cause, 1);
        idle(2);

        // R3: overflow then data fault on one instruction -> overflow wins
        step(1, 32'h3100, 0, 0, 0, 0, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        step(0, '0, 0, 0, 1, 0, 0);
        step(0, '0, 0, 0, 0, 1, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        check("R3 overflow beats data fault", cause, 3);
        check("R5 epc overflow", epc, 32'h3100);
        idle(2);

        // R4: interrupt with faulty instruction at commit -> cause 0
        step(1, 32'h4000, 1, 0, 0, 0, 0);
        idle(2);
        step(0, '0, 0, 0, 0, 1, 1);
        step(0, '0, 0, 0, 0, 0, 0);
        check("R4 irq overrides", cause, 0);
        check("R4 irq epc", epc, 32'h4000);

        // R4/R9: interrupt and faults with empty pipe have no effect
        r0 = redirects;
        step(0, '0, 0, 1, 1, 1, 1);
        step(0, '0, 0, 1, 1, 1, 1);
        check("R4/R9 ignored on empty stages", redirects - r0, 0);
        check("R9 cause unchanged", cause, 0);

        // R10: older data fault wins over younger fetch fault
        step(1, 32'h5000, 0, 0, 0, 0, 0);
        step(1, 32'h5004, 1, 0, 0, 0, 0);
        step(1, 32'h5008, 0, 1, 0, 0, 0);
        step(0, '0, 0, 0, 0, 1, 0);
        step(0, '0, 0, 0, 0, 0, 0);
        check("R10 older wins cause", cause, 4);
        check("R10 older wins epc", epc, 32'h5000);
        idle(4);

        // mixed stream against the model
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) != 0, 32'h8000 + 4*i,
                 $urandom_range(0, 40) == 0, $urandom_range(0, 30) == 0,
                 $urandom_range(0, 30) == 0, $urandom_range(0, 30) == 0,
                 $urandom_range(0, 60) == 0);
        end
        idle(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule